// File: doc/BRIEF.md
# Serial Port Byte-Transfer Channel Pair

This block moves bytes between one serial port and memory without the processor taking part. It has two channels: a receive channel that stores each byte the port delivers, and a transmit channel that fetches the next byte from memory whenever the port's transmitter can take one. Each channel has a 32-bit address pointer and a 16-bit byte counter, both written by software through a small register port. A single programming moves up to 65,535 contiguous bytes. When a channel's counter reaches zero it stops and holds its end-of-transfer flag high until software writes a new non-zero count.

Both channels share one memory port that uses a request/grant handshake. A single sequencer state machine serves them, one byte at a time. Its states are ST_IDLE, ST_RX_WRITE, ST_TX_FETCH and ST_TX_WAIT. It moves from ST_IDLE to ST_RX_WRITE on an accepted receive byte, and from ST_IDLE to ST_TX_FETCH when the transmitter is ready. ST_RX_WRITE returns to ST_IDLE on grant. ST_TX_FETCH moves to ST_TX_WAIT on grant, and ST_TX_WAIT returns to ST_IDLE when read data returns. When both channels are eligible in the same idle cycle, receive goes first.

Top module: `sdma_pair`

## Requirements
- R1: After reset both pointers and both counters read zero, both end flags are high, and no memory request, receive acknowledge or transmit strobe is active.
- R2: A register write with reg_wr_en high loads the register chosen by reg_sel (0 = receive pointer, 1 = receive count, 2 = transmit pointer, 3 = transmit count), and reg_rdata returns the register that reg_sel currently selects, with a count zero-extended.
- R3: While the receive count is non-zero, a byte offered with rx_valid is taken with a one-cycle rx_ack and then written to memory with mem_we high at the receive pointer.
- R4: While the transmit count is non-zero and tx_ready is high, the byte at the transmit pointer is read from memory, and the byte returned on mem_rdata appears on tx_data with a one-cycle tx_valid strobe.
- R5: Each completed byte (a write grant for receive, or returned read data for transmit) raises that channel's pointer by one and lowers its count by one.
- R6: A channel whose count is zero ignores its port: rx_valid gets no rx_ack and starts no memory request, and tx_ready starts no read.
- R7: Each end flag is high exactly while its channel's count is zero, and drops after a non-zero count is written.
- R8: When a receive byte and a ready transmitter are both eligible in the same idle cycle, the receive byte is served first.
- R9: Once raised, mem_req, mem_we and mem_addr stay unchanged until mem_grant, and only one access is in flight at a time.
- R10: A count write during an active transfer replaces the remaining count at once. It wins over a decrement in the same cycle, and the pointer still advances.
- R11: A byte that completes when its channel's count is already zero leaves the count at zero; it never wraps to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 rx ptr, 1 rx count, 2 tx ptr, 3 tx count) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register value |
| rx_valid | input | 1 | Port has a received byte |
| rx_data | input | 8 | Received byte |
| rx_ack | output | 1 | Byte taken from the port |
| tx_ready | input | 1 | Port transmitter can take a byte |
| tx_valid | output | 1 | One-cycle strobe: byte on tx_data |
| tx_data | output | 8 | Byte for the transmitter |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_grant | input | 1 | Access accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read byte |

## Verification
Two of this block's functions can fall in the same cycle in two ways. A software count write can meet a byte completion that decrements the same counter. A received byte can meet a ready transmitter while the sequencer is idle. For the first, the bench raises the count write in the same cycle the memory model grants a receive write, then reads back the count and the pointer: the count must equal the written value and the pointer must have advanced. For the second, the bench raises rx_valid and tx_ready together and checks that the acknowledge and the first memory request belong to receive. A scoreboard then compares every memory write and every transmitted byte with its expected address and value.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam int NUM_CH = 2;
    localparam int CH_RX  = 0;
    localparam int CH_TX  = 1;

    typedef enum logic [1:0] {
        SEL_RX_PTR = 2'd0,
        SEL_RX_CNT = 2'd1,
        SEL_TX_PTR = 2'd2,
        SEL_TX_CNT = 2'd3
    } sdma_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RX_WRITE,
        ST_TX_FETCH,
        ST_TX_WAIT
    } sdma_state_e;

endpackage

// File: rtl/sdma_chan.sv
module sdma_chan #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ptr,
    input  logic              wr_cnt,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr,
    output logic [CNT_W-1:0]  cnt,
    output logic              live
);

    // pointer: software write wins over an increment in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (wr_ptr) begin
            ptr <= wdata;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

    // count: software write wins; a decrement never passes below zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_cnt) begin
            cnt <= wdata[CNT_W-1:0];
        end else if (step && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign live = (cnt != '0);

endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_live,
    input  logic              tx_live,
    input  logic [ADDR_W-1:0] rx_ptr,
    input  logic [ADDR_W-1:0] tx_ptr,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ack,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_grant,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rx_step,
    output logic              tx_step,
    output logic              seq_idle
);

    sdma_state_e state_q, state_d;
    logic [DATA_W-1:0] rx_hold_q;
    logic [DATA_W-1:0] tx_data_q;
    logic              tx_valid_q;
    logic              rx_go, tx_go;

    // eligibility in the idle state; receive has priority
    assign rx_go = (state_q == ST_IDLE) && rx_live && rx_valid;
    assign tx_go = (state_q == ST_IDLE) && !rx_go && tx_live && tx_ready && !tx_valid_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_go) begin
                    state_d = ST_RX_WRITE;
                end else if (tx_go) begin
                    state_d = ST_TX_FETCH;
                end
            end
            ST_RX_WRITE: if (mem_grant)  state_d = ST_IDLE;
            ST_TX_FETCH: if (mem_grant)  state_d = ST_TX_WAIT;
            ST_TX_WAIT:  if (mem_rvalid) state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        rx_step  = 1'b0;
        tx_step  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RX_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = rx_ptr;
                rx_step  = mem_grant;
            end
            ST_TX_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = tx_ptr;
            end
            ST_TX_WAIT: begin
                tx_step  = mem_rvalid;
            end
        endcase
    end

    // data holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_hold_q  <= '0;
            tx_data_q  <= '0;
            tx_valid_q <= 1'b0;
        end else begin
            if (rx_go) begin
                rx_hold_q <= rx_data;
            end
            tx_valid_q <= (state_q == ST_TX_WAIT) && mem_rvalid;
            if ((state_q == ST_TX_WAIT) && mem_rvalid) begin
                tx_data_q <= mem_rdata;
            end
        end
    end

    assign rx_ack    = rx_go;
    assign mem_wdata = rx_hold_q;
    assign tx_valid  = tx_valid_q;
    assign tx_data   = tx_data_q;
    assign seq_idle  = (state_q == ST_IDLE);

endmodule

// File: rtl/sdma_pair.sv
module sdma_pair
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ack,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_grant,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int PAD_W = ADDR_W - CNT_W;

    logic [ADDR_W-1:0] ptr_q  [NUM_CH];
    logic [CNT_W-1:0]  cnt_q  [NUM_CH];
    logic [NUM_CH-1:0] live;
    logic [NUM_CH-1:0] step;
    logic              seq_idle;
    logic              rx_end, tx_end;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic wr_p, wr_c;
        assign wr_p = reg_wr_en && (reg_sel == 2'(2 * ch));
        assign wr_c = reg_wr_en && (reg_sel == 2'(2 * ch + 1));

        sdma_chan #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_ptr (wr_p),
            .wr_cnt (wr_c),
            .wdata  (reg_wdata),
            .step   (step[ch]),
            .ptr    (ptr_q[ch]),
            .cnt    (cnt_q[ch]),
            .live   (live[ch])
        );
    end

    sdma_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_live    (live[CH_RX]),
        .tx_live    (live[CH_TX]),
        .rx_ptr     (ptr_q[CH_RX]),
        .tx_ptr     (ptr_q[CH_TX]),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_ack     (rx_ack),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_grant  (mem_grant),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .rx_step    (step[CH_RX]),
        .tx_step    (step[CH_TX]),
        .seq_idle   (seq_idle)
    );

    assign rx_end = !live[CH_RX];
    assign tx_end = !live[CH_TX];

    // register read-back
    always_comb begin
        unique case (sdma_sel_e'(reg_sel))
            SEL_RX_PTR: reg_rdata = ptr_q[CH_RX];
            SEL_RX_CNT: reg_rdata = {{PAD_W{1'b0}}, cnt_q[CH_RX]};
            SEL_TX_PTR: reg_rdata = ptr_q[CH_TX];
            SEL_TX_CNT: reg_rdata = {{PAD_W{1'b0}}, cnt_q[CH_TX]};
        endcase
    end

endmodule

// File: rtl/sdma_pair_chk.sv
module sdma_pair_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_ack,
    input logic              rx_end,
    input logic              tx_valid,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_grant,
    input logic              reg_wr_en,
    input logic [1:0]        reg_sel,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic              seq_idle
);

    // R3
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |=> !rx_ack);

    // R3
    ack_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |=> (mem_req && mem_we));

    // R4
    tx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

    // R6
    ack_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |-> !rx_end);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_grant) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // R9
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !seq_idle);

    // R11
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_cnt) == '0 && !($past(reg_wr_en) && $past(reg_sel) == 2'd1))
        |-> (rx_cnt == '0));

endmodule

bind sdma_pair sdma_pair_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_ack    (rx_ack),
    .rx_end    (rx_end),
    .tx_valid  (tx_valid),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_grant (mem_grant),
    .reg_wr_en (reg_wr_en),
    .reg_sel   (reg_sel),
    .rx_cnt    (cnt_q[0]),
    .seq_idle  (seq_idle)
);

// File: tb/sdma_pair_test.sv
`timescale 1ns/100ps
module sdma_pair_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ack;
    logic        tx_ready = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_grant = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;

    always #2.5 clk = ~clk;

    sdma_pair uut (.*);

    int n_chk = 0;
    int n_fail = 0;
    int gnt_delay = 0;
    int wcnt = 0;
    logic        rd_pend = 1'b0;
    logic [31:0] rd_addr = '0;
    logic [31:0] held_addr = '0;
    logic        holding = 1'b0;
    logic [39:0] rx_exp_q[$];
    logic [7:0]  tx_exp_q[$];

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model and scoreboard monitor, all at the falling edge
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (rd_pend) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem_byte(rd_addr);
            rd_pend    = 1'b0;
        end
        mem_grant = 1'b0;
        if (rst_n && mem_req) begin
            if (!holding) begin
                held_addr = mem_addr;
                holding   = 1'b1;
            end else begin
                check(mem_addr == held_addr, "R9 address held until grant", mem_addr, held_addr);
            end
            if (wcnt >= gnt_delay) begin
                mem_grant = 1'b1;
                wcnt      = 0;
                holding   = 1'b0;
                if (mem_we) begin
                    if (rx_exp_q.size() == 0) begin
                        check(1'b0, "R3 unexpected write", {24'd0, mem_wdata}, 32'd0);
                    end else begin
                        logic [39:0] e;
                        e = rx_exp_q.pop_front();
                        check(mem_addr == e[39:8] && mem_wdata == e[7:0],
                              "R3 write addr/data", mem_addr ^ {24'd0, mem_wdata}, e[39:8] ^ {24'd0, e[7:0]});
                    end
                end else begin
                    rd_pend = 1'b1;
                    rd_addr = mem_addr;
                end
            end else begin
                wcnt++;
            end
        end
        if (rst_n && tx_valid) begin
            if (tx_exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected tx byte", {24'd0, tx_data}, 32'd0);
            end else begin
                logic [7:0] t;
                t = tx_exp_q.pop_front();
                check(tx_data == t, "R4 tx byte", {24'd0, tx_data}, {24'd0, t});
            end
        end
    end

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [31:0] v);
        @(negedge clk);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    // driver: offer one receive byte and push its expected memory write
    task automatic send_rx(input logic [31:0] addr, input logic [7:0] b);
        bit acked;
        rx_exp_q.push_back({addr, b});
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        do begin
            #1 acked = rx_ack;
            @(negedge clk);
        end while (!acked);
        rx_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rx_exp_q.size() == 0 && tx_exp_q.size() == 0 && !mem_req) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            rd_reg(2'(s), v);
            check(v == 32'd0, "R1 register zero after reset", v, 32'd0);
        end
        check(uut.rx_end && uut.tx_end && !mem_req && !rx_ack && !tx_valid,
              "R1 end flags high, idle outputs", {uut.rx_end, uut.tx_end, mem_req, rx_ack, tx_valid}, 32'h18);

        // R2, R7: program receive channel
        wr_reg(2'd0, 32'h0000_1000);
        wr_reg(2'd1, 32'd3);
        rd_reg(2'd0, v); check(v == 32'h1000, "R2 rx pointer readback", v, 32'h1000);
        rd_reg(2'd1, v); check(v == 32'd3, "R2 rx count readback", v, 32'd3);
        check(!uut.rx_end, "R7 rx end flag cleared", {31'd0, uut.rx_end}, 32'd0);

        // R3, R5: three receive bytes with grant delay 1
        gnt_delay = 1;
        send_rx(32'h1000, 8'h11);
        send_rx(32'h1001, 8'h22);
        send_rx(32'h1002, 8'h33);
        drain();
        rd_reg(2'd0, v); check(v == 32'h1003, "R5 rx pointer advanced", v, 32'h1003);
        rd_reg(2'd1, v); check(v == 32'd0, "R5 rx count exhausted", v, 32'd0);
        check(uut.rx_end, "R7 rx end flag set at zero", {31'd0, uut.rx_end}, 32'd1);

        // R6: rx_valid ignored at zero count
        begin
            bit seen = 1'b0;
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'hEE;
            for (int i = 0; i < 10; i++) begin
                #1 if (rx_ack || mem_req) seen = 1'b1;
                @(negedge clk);
            end
            rx_valid = 1'b0;
            check(!seen, "R6 no ack or request at zero count", {31'd0, seen}, 32'd0);
        end

        // R4, R5, R9: transmit four bytes with grant delay 3
        gnt_delay = 3;
        tx_ready  = 1'b1;
        for (int i = 0; i < 4; i++) tx_exp_q.push_back(mem_byte(32'h2000 + 32'(i)));
        wr_reg(2'd2, 32'h0000_2000);
        wr_reg(2'd3, 32'd4);
        drain();
        rd_reg(2'd2, v); check(v == 32'h2004, "R5 tx pointer advanced", v, 32'h2004);
        check(uut.tx_end, "R7 tx end flag set", {31'd0, uut.tx_end}, 32'd1);

        // R8: receive and transmit eligible in the same idle cycle
        gnt_delay = 0;
        tx_ready  = 1'b0;
        wr_reg(2'd0, 32'h0000_3000);
        wr_reg(2'd1, 32'd1);
        wr_reg(2'd2, 32'h0000_4000);
        wr_reg(2'd3, 32'd1);
        rx_exp_q.push_back({32'h3000, 8'h77});
        tx_exp_q.push_back(mem_byte(32'h4000));
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h77; tx_ready = 1'b1;
        #1 check(rx_ack, "R8 receive acknowledged first", {31'd0, rx_ack}, 32'd1);
        @(negedge clk);
        rx_valid = 1'b0;
        check(mem_req && mem_we && mem_addr == 32'h3000, "R8 first access is receive write",
              mem_addr, 32'h3000);
        drain();
        tx_ready = 1'b0;

        // R10: count write in the same cycle as a decrement
        wr_reg(2'd0, 32'h0000_5000);
        wr_reg(2'd1, 32'd8);
        rx_exp_q.push_back({32'h5000, 8'h3C});
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h3C;
        @(negedge clk);
        rx_valid = 1'b0;
        reg_wr_en = 1'b1; reg_sel = 2'd1; reg_wdata = 32'd5;
        @(negedge clk);
        reg_wr_en = 1'b0;
        rd_reg(2'd1, v); check(v == 32'd5, "R10 written count wins over decrement", v, 32'd5);
        rd_reg(2'd0, v); check(v == 32'h5001, "R10 pointer still advances", v, 32'h5001);
        wr_reg(2'd1, 32'd0);
        check(uut.rx_end, "R7 end flag after zero write", {31'd0, uut.rx_end}, 32'd1);

        // R11: byte completes after count was set to zero
        gnt_delay = 2;
        wr_reg(2'd0, 32'h0000_6000);
        wr_reg(2'd1, 32'd2);
        rx_exp_q.push_back({32'h6000, 8'h5A});
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h5A;
        @(negedge clk);
        rx_valid = 1'b0;
        reg_wr_en = 1'b1; reg_sel = 2'd1; reg_wdata = 32'd0;
        @(negedge clk);
        reg_wr_en = 1'b0;
        drain();
        rd_reg(2'd1, v); check(v == 32'd0, "R11 count stays zero, no wrap", v, 32'd0);
        rd_reg(2'd0, v); check(v == 32'h6001, "R11 pointer advanced", v, 32'h6001);

        check(rx_exp_q.size() == 0 && tx_exp_q.size() == 0, "R3 R4 scoreboard empty",
              32'(rx_exp_q.size() + tx_exp_q.size()), 32'd0);
        finish_run();
    end

endmodule